// File: doc/BRIEF.md
# Plug-and-Play Initiation Key Detector

This block sits behind the plug-and-play address port of a configurable expansion card. While the card's configuration controller reports the wait-for-key phase, every byte written to the port is compared against the next byte of a fixed 32-byte initiation sequence. Once all 32 bytes have arrived in the correct order, the block emits a single-cycle pulse. The controller uses that pulse to move the card into its sleep phase.

The expected bytes are not stored in a table. An 8-bit linear feedback shift register produces them on the fly. It starts from the seed 0x6A and steps once for each correctly matched byte. Any wrong byte sends the match back to the start of the sequence.

In every other phase, a write to the same port is a register-index select. The written byte is latched into an index register that the rest of the configuration logic decodes.

Top module: `pnp_key_detect`

## Requirements
- R1: After reset, `key_done` is 0, `reg_index` is 0x00, and matching starts at the first key byte.
- R2: The expected key byte k(0) is 0x6A. Each following byte is k(n+1) = {k(n)[1]^k(n)[0], k(n)[7:1]}, so the sequence runs 0x6A, 0xB5, 0xDA, ... up to k(31) = 0x39.
- R3: A write that is the 32nd correct byte in a row makes `key_done` high for exactly one cycle. The pulse is registered on the clock edge that samples that write.
- R4: Key matching happens only for writes made while `phase` equals 2'b00 (wait-for-key). The other codes are 2'b01 sleep, 2'b10 isolation and 2'b11 configuration. Writes in those phases neither advance nor clear the match progress.
- R5: A write in wait-for-key that differs from the expected byte resets the match to the first key byte. That write is not counted as a first byte, even when its value is 0x6A.
- R6: After a completed key, the match restarts. A further pulse needs another full 32 correct bytes.
- R7: A write in any phase other than wait-for-key loads `wr_data` into `reg_index`, visible the cycle after. Writes in wait-for-key leave `reg_index` unchanged.
- R8: In a cycle without `wr_stb`, the match progress and `reg_index` do not change, and `key_done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_stb | input | 1 | One-cycle strobe for a write to the address port |
| wr_data | input | 8 | Byte written to the address port |
| phase | input | 2 | Card phase: 00 wait-for-key, 01 sleep, 10 isolation, 11 configuration |
| key_done | output | 1 | One-cycle pulse when the full key has been received |
| reg_index | output | 8 | Latched configuration register index |

## Verification
The bench goes after a wrong byte in the middle of the key whose value is 0x6A. A design that restarted at the second byte would then accept the remaining bytes as a valid key and pulse. It also sends the whole key in sleep phase and splits a key around a configuration-phase index write. A design that ignored the phase, or cleared progress on foreign-phase writes, would pulse wrongly or miss the pulse. A second back-to-back key checks that the sequence generator is reseeded after the wrap. Without the reseed, the next attempt would expect 0x9C and never complete.

// File: rtl/pnp_key_pkg.sv
package pnp_key_pkg;

  typedef enum logic [1:0] {
    PH_WAIT_KEY = 2'b00,
    PH_SLEEP    = 2'b01,
    PH_ISOLATE  = 2'b10,
    PH_CONFIG   = 2'b11
  } pnp_phase_e;

  localparam int unsigned   KEY_BYTES = 32;
  localparam logic [7:0]    KEY_SEED  = 8'h6A;

endpackage

// File: rtl/key_lfsr.sv
module key_lfsr #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] SEED = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         reload,
  output logic [W-1:0] q
);

  logic [W-1:0] q_next;
  logic         fb;

  assign fb = q[1] ^ q[0];

  always_comb begin
    q_next = q;
    if (reload) begin
      q_next = SEED;
    end else if (adv) begin
      q_next = {fb, q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= SEED;
    end else if (reload || adv) begin
      q <= q_next;
    end
  end

endmodule

// File: rtl/match_counter.sv
module match_counter #(
  parameter int unsigned LEN   = 32,
  localparam int unsigned CNT_W = $clog2(LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             miss,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  logic [CNT_W-1:0] cnt_next;

  assign last = (cnt == CNT_W'(LEN - 1));

  always_comb begin
    cnt_next = cnt;
    if (miss) begin
      cnt_next = '0;
    end else if (hit) begin
      cnt_next = last ? '0 : cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (hit || miss) begin
      cnt <= cnt_next;
    end
  end

endmodule

// File: rtl/index_reg.sv
module index_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end

endmodule

// File: rtl/pnp_key_detect.sv
module pnp_key_detect
  import pnp_key_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned KEY_LEN = KEY_BYTES,
  parameter logic [DATA_W-1:0] SEED = KEY_SEED,
  localparam int unsigned CNT_W = $clog2(KEY_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        phase,
  output logic              key_done,
  output logic [DATA_W-1:0] reg_index
);

  // Reset synchronizer: asserts asynchronously, releases on a clock edge
  logic [1:0] rst_sync;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync[1];

  // Write classification
  pnp_phase_e       ph;
  logic             in_wait_key;
  logic             key_wr;
  logic             idx_wr;
  logic             hit;
  logic             miss;
  logic             wrap;
  logic             done_next;
  logic [DATA_W-1:0] expect_byte;
  logic [CNT_W-1:0] match_cnt;
  logic             cnt_last;

  assign ph          = pnp_phase_e'(phase);
  assign in_wait_key = (ph == PH_WAIT_KEY);
  assign key_wr      = wr_stb && in_wait_key;
  assign idx_wr      = wr_stb && !in_wait_key;
  assign hit         = key_wr && (wr_data == expect_byte);
  assign miss        = key_wr && (wr_data != expect_byte);
  assign wrap        = hit && cnt_last;
  assign done_next   = wrap;

  key_lfsr #(
    .W    (DATA_W),
    .SEED (SEED)
  ) u_lfsr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .adv    (hit),
    .reload (miss || wrap),
    .q      (expect_byte)
  );

  match_counter #(
    .LEN (KEY_LEN)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .hit   (hit),
    .miss  (miss),
    .cnt   (match_cnt),
    .last  (cnt_last)
  );

  index_reg #(
    .W (DATA_W)
  ) u_idx (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (idx_wr),
    .d     (wr_data),
    .q     (reg_index)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      key_done <= 1'b0;
    end else begin
      key_done <= done_next;
    end
  end

endmodule

// File: rtl/pnp_key_detect_chk.sv
module pnp_key_detect_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned KEY_LEN = 32,
  parameter logic [DATA_W-1:0] SEED = 8'h6A
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [DATA_W-1:0] wr_data,
  input logic [1:0]        phase,
  input logic              key_done,
  input logic [DATA_W-1:0] reg_index,
  input logic [CNT_W-1:0]  match_cnt,
  input logic [DATA_W-1:0] expect_byte
);

  logic wfk_wr;
  logic oth_wr;
  assign wfk_wr = wr_stb && (phase == 2'b00);
  assign oth_wr = wr_stb && (phase != 2'b00);

  AST_SEED_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (match_cnt == '0) |-> (expect_byte == SEED)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    key_done |=> !key_done); // R3

  AST_DONE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wfk_wr && (wr_data == expect_byte) && (match_cnt == CNT_W'(KEY_LEN - 1)))
      |=> (key_done && (match_cnt == '0))); // R6

  AST_FOREIGN_PHASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    oth_wr |=> ($stable(match_cnt) && !key_done)); // R4

  AST_MISMATCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (wfk_wr && (wr_data != expect_byte))
      |=> ((match_cnt == '0) && (expect_byte == SEED) && !key_done)); // R5

  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    oth_wr |=> (reg_index == $past(wr_data))); // R7

  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !oth_wr |=> $stable(reg_index)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(match_cnt) && $stable(expect_byte) && !key_done)); // R8

endmodule

bind pnp_key_detect pnp_key_detect_chk #(
  .DATA_W  (DATA_W),
  .CNT_W   (CNT_W),
  .KEY_LEN (KEY_LEN),
  .SEED    (SEED)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wr_stb      (wr_stb),
  .wr_data     (wr_data),
  .phase       (phase),
  .key_done    (key_done),
  .reg_index   (reg_index),
  .match_cnt   (match_cnt),
  .expect_byte (expect_byte)
);

// File: tb/pnp_key_detect_tb.sv
module pnp_key_detect_tb;

  localparam time CLK_PERIOD = 10ns;

  logic       clk;
  logic       rst_n;
  logic       wr_stb;
  logic [7:0] wr_data;
  logic [1:0] phase;
  logic       key_done;
  logic [7:0] reg_index;

  int n_tests;
  int n_fail;

  pnp_key_detect u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .phase     (phase),
    .key_done  (key_done),
    .reg_index (reg_index)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Reference key computed from the R2 recurrence
  logic [7:0] key_tab [32];
  initial begin
    key_tab[0] = 8'h6A;
    for (int i = 1; i < 32; i++)
      key_tab[i] = {key_tab[i-1][1] ^ key_tab[i-1][0], key_tab[i-1][7:1]};
  end

  // Reference model state
  int         m_cnt;
  logic [7:0] m_idx;

  // Scoreboard queues
  logic       q_done [$];
  logic [7:0] q_idx  [$];
  string      q_tag  [$];

  task automatic push_exp(input logic d, input string tag);
    q_done.push_back(d);
    q_idx.push_back(m_idx);
    q_tag.push_back(tag);
  endtask

  task automatic do_write(input logic [7:0] d, input logic [1:0] ph, input string tag);
    logic exp_done;
    @(negedge clk);
    wr_stb  = 1'b1;
    wr_data = d;
    phase   = ph;
    @(posedge clk);
    exp_done = 1'b0;
    if (ph == 2'b00) begin
      if (d == key_tab[m_cnt]) begin
        if (m_cnt == 31) begin
          exp_done = 1'b1;
          m_cnt = 0;
        end else begin
          m_cnt = m_cnt + 1;
        end
      end else begin
        m_cnt = 0;
      end
    end else begin
      m_idx = d;
    end
    push_exp(exp_done, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_stb = 1'b0;
      @(posedge clk);
      push_exp(1'b0, tag);
    end
  endtask

  task automatic send_key(input int from, input int to, input logic [1:0] ph, input string tag);
    for (int i = from; i <= to; i++) do_write(key_tab[i], ph, tag);
  endtask

  // Monitor: compares results one cycle after each driven edge
  always @(negedge clk) begin
    if (rst_n && q_done.size() > 0) begin
      logic       ed;
      logic [7:0] ei;
      string      t;
      ed = q_done.pop_front();
      ei = q_idx.pop_front();
      t  = q_tag.pop_front();
      n_tests++;
      if (key_done !== ed || reg_index !== ei) begin
        n_fail++;
        $display("FAIL %s: key_done=%0b reg_index=%02h expected key_done=%0b reg_index=%02h",
                 t, key_done, reg_index, ed, ei);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0;
    n_fail  = 0;
    m_cnt   = 0;
    m_idx   = 8'h00;
    rst_n   = 1'b0;
    wr_stb  = 1'b0;
    wr_data = 8'h00;
    phase   = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state at the ports
    n_tests++;
    if (key_done !== 1'b0 || reg_index !== 8'h00) begin
      n_fail++;
      $display("FAIL R1 reset: key_done=%0b reg_index=%02h expected 0 and 00", key_done, reg_index);
    end

    // R2 / R3: full key from reset produces one pulse
    send_key(0, 31, 2'b00, "R2 R3 full key");
    idle(2, "R3 pulse ends");

    // R6: second key right after needs all 32 bytes again
    send_key(0, 30, 2'b00, "R6 partial second key");
    idle(1, "R8 idle mid key");
    do_write(key_tab[31], 2'b00, "R6 second key completes");
    idle(1, "R3 pulse ends");

    // R5: wrong byte equal to 0x6A mid key, then the rest from byte 1
    send_key(0, 9, 2'b00, "R5 prefix");
    do_write(8'h6A, 2'b00, "R5 mismatch 6A");
    send_key(1, 31, 2'b00, "R5 no pulse after restart");
    idle(1, "R5 idle");
    send_key(0, 31, 2'b00, "R5 full key after restart");
    idle(1, "R5 pulse ends");

    // R5: plain mismatch on the last byte
    send_key(0, 30, 2'b00, "R5 prefix 31");
    do_write(8'h00, 2'b00, "R5 last byte wrong");
    idle(1, "R5 idle");

    // R4 / R7: key in sleep phase does nothing but load index
    send_key(0, 31, 2'b01, "R4 R7 key in sleep phase");
    idle(1, "R7 index held");

    // R4 / R7: config write in the middle of a key keeps progress
    send_key(0, 15, 2'b00, "R4 first half");
    do_write(8'hA5, 2'b11, "R7 index load config");
    do_write(8'h3C, 2'b10, "R7 index load isolation");
    send_key(16, 31, 2'b00, "R4 second half completes");
    do_write(8'h77, 2'b00, "R7 wait-key write keeps index");
    idle(2, "R8 idle");

    // R3: last byte in a foreign phase must not complete the key
    send_key(0, 30, 2'b00, "R3 prefix");
    do_write(key_tab[31], 2'b01, "R3 last byte wrong phase");
    do_write(key_tab[31], 2'b00, "R3 last byte right phase");
    idle(3, "R8 drain");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule